// File: doc/BRIEF.md
# CW Doppler Beamformer Phase Configuration Port

This block is the serial programming port of an eight-channel continuous-wave Doppler receiver. Each channel needs a 5-bit setting: a 4-bit phase selection and a channel enable. The settings enter a 40-bit shift chain through an active-low select, a programming clock and a serial data input. The chain's far end drives a serial data output, so any number of devices can be cascaded on one programming clock. When the select returns high, the whole chain is copied in one step into per-channel preset registers. These registers preset the I/Q phase-divider counters.

The presets may only be loaded while the mixer clock is stopped. The block watches the mixer clock in a short window of system-clock cycles on either side of each load. It reports on a status output whether that load was clean. The serial pins and the mixer clock are all sampled through synchronisers on the system clock. The programming clock must therefore be several times slower than the system clock, as it is at the required 10 MHz maximum.

Top module: `cwd_cfg_port`

## Requirements
- R1: After reset, all phase outputs and enable outputs are 0, the serial output is 0, the load-fault output is 0 and no load pulse is present.
- R2: The chain changes only on a rising edge of the programming clock while the select is low. Clock edges and data taken while the select is high have no effect on the chain.
- R3: Serial bits enter at the chain's top and move one position toward bit 0 per clock. After 40 clocks, the first bit sent is bit 0 of channel 0. Each channel field arrives LSB first, and channel 0's field comes first.
- R4: Within channel c's 5-bit field (chain bits 5c..5c+4), bits 0..3 drive phase output c (ch_phase[4c+3:4c]) and bit 4 drives ch_enable[c].
- R5: The serial output shows chain bit 0 and updates only on falling edges of the programming clock. A cascaded device therefore receives the bits that leave this chain, in the order they leave.
- R6: When more than 40 bits are clocked in one select-low window, only the last 40 bits remain.
- R7: When fewer than 40 bits are clocked, a load still happens. The chain then holds its previous contents shifted by the number of new bits, with the new bits at the top.
- R8: A rising edge of the select copies the chain into every channel's preset register and raises the load pulse for exactly one system clock. The presets do not change at any other time.
- R9: If the mixer clock changes level within WIN (8) system-clock cycles before or after a load, load_fault is 1 once the window after that load closes.
- R10: If a load sees no mixer-clock change in its window, load_fault returns to 0 when that window closes. Otherwise load_fault holds its value between loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all serial and mixer signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_clk | input | 1 | Programming clock |
| prog_sel_n | input | 1 | Active-low select; its rising edge loads the presets |
| prog_din | input | 1 | Serial data in |
| prog_dout | output | 1 | Serial data out to the next device in the cascade |
| mix_clk | input | 1 | Mixer clock, monitored for activity around loads |
| ch_phase | output | 32 | Phase-selection presets, 4 bits per channel, channel 0 in the low bits |
| ch_enable | output | 8 | Per-channel enable presets |
| load_pulse | output | 1 | One-cycle strobe when the presets are loaded |
| load_fault | output | 1 | Set when the most recent load saw the mixer clock move in its window |

## Verification
The hardest case is a mixer-clock edge just inside the guard window around a load. A pulse a few cycles before the select rises must be flagged, while the same pulse tens of cycles earlier must not be. The bench times single mixer pulses in system-clock cycles relative to the select edge. It places one pulse two cycles before the edge and one sixty cycles before it. It also runs a free-running mixer clock through a load. Between these loads, clean loads check that the flag clears. The scoreboard checks the preset contents of every one of these loads.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned CH_DEFAULT  = 8;
  localparam int unsigned PH_DEFAULT  = 4;
  localparam int unsigned WIN_DEFAULT = 8;

  typedef enum logic {
    GUARD_IDLE  = 1'b0,
    GUARD_WATCH = 1'b1
  } guard_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] dly
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [2:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {3{RST_VAL[i]}};
      else        pipe_q <= {pipe_q[1:0], async_in[i]};
    end
    assign lvl[i] = pipe_q[1];
    assign dly[i] = pipe_q[2];
  end
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int unsigned NCH = 8,
  parameter int unsigned FW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              out_en,
  input  logic              din,
  output logic [NCH*FW-1:0] chain,
  output logic              dout
);
  localparam int unsigned CW = NCH * FW;

  function automatic logic [CW-1:0] push_top(input logic [CW-1:0] cur, input logic b);
    return {b, cur[CW-1:1]};
  endfunction

  logic [CW-1:0] chain_q;
  logic          dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (shift_en) chain_q <= push_top(chain_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout_q <= 1'b0;
    else if (out_en) dout_q <= chain_q[0];
  end

  assign chain = chain_q;
  assign dout  = dout_q;

  assert_chain_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chain_q));
  assert_entry_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> chain_q[CW-1] == $past(din));
  assert_dout_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> $stable(dout_q));
endmodule

// File: rtl/cfg_preset_bank.sv
module cfg_preset_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned PW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_en,
  input  logic [NCH*(PW+1)-1:0]  chain,
  output logic [NCH*PW-1:0]      ch_phase,
  output logic [NCH-1:0]         ch_enable,
  output logic                   load_pulse
);
  localparam int unsigned FW = PW + 1;

  function automatic logic [PW-1:0] field_phase(input logic [NCH*FW-1:0] v, input int unsigned c);
    return v[c*FW +: PW];
  endfunction

  function automatic logic field_en(input logic [NCH*FW-1:0] v, input int unsigned c);
    return v[c*FW + PW];
  endfunction

  logic [NCH*PW-1:0] phase_q;
  logic [NCH-1:0]    en_q;
  logic              pulse_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phase_q[c*PW +: PW] <= '0;
        en_q[c]             <= 1'b0;
      end else if (load_en) begin
        phase_q[c*PW +: PW] <= field_phase(chain, c);
        en_q[c]             <= field_en(chain, c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= load_en;
  end

  assign ch_phase   = phase_q;
  assign ch_enable  = en_q;
  assign load_pulse = pulse_q;

  assert_preset_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(phase_q) && $stable(en_q)));
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);
endmodule

// File: rtl/cfg_load_guard.sv
module cfg_load_guard
  import cfg_pkg::*;
#(
  parameter int unsigned WIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_ev,
  input  logic mix_edge,
  output logic load_fault
);
  localparam int unsigned CNTW = $clog2(WIN + 1);
  localparam logic [CNTW-1:0] WIN_C = CNTW'(WIN);

  guard_state_e    state_q;
  logic [CNTW-1:0] since_q;
  logic [CNTW-1:0] left_q;
  logic            dirty_q;
  logic            fault_q;
  logic            recent;
  logic            close_now;

  assign recent    = since_q < WIN_C;
  assign close_now = (state_q == GUARD_WATCH) && (left_q == CNTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          since_q <= WIN_C;
    else if (mix_edge)   since_q <= '0;
    else if (recent)     since_q <= since_q + CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GUARD_IDLE;
      left_q  <= '0;
      dirty_q <= 1'b0;
      fault_q <= 1'b0;
    end else if (state_q == GUARD_IDLE) begin
      if (load_ev) begin
        state_q <= GUARD_WATCH;
        left_q  <= WIN_C;
        dirty_q <= recent | mix_edge;
      end
    end else if (close_now) begin
      fault_q <= dirty_q | mix_edge;
      state_q <= GUARD_IDLE;
      left_q  <= '0;
    end else begin
      dirty_q <= dirty_q | mix_edge;
      left_q  <= left_q - CNTW'(1);
    end
  end

  assign load_fault = fault_q;

  assert_fault_at_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !close_now |=> $stable(fault_q));
  assert_late_edge_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (close_now && mix_edge) |=> fault_q);
endmodule

// File: rtl/cwd_cfg_port.sv
module cwd_cfg_port
  import cfg_pkg::*;
#(
  parameter int unsigned NCH = CH_DEFAULT,
  parameter int unsigned PW  = PH_DEFAULT,
  parameter int unsigned WIN = WIN_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_clk,
  input  logic              prog_sel_n,
  input  logic              prog_din,
  output logic              prog_dout,
  input  logic              mix_clk,
  output logic [NCH*PW-1:0] ch_phase,
  output logic [NCH-1:0]    ch_enable,
  output logic              load_pulse,
  output logic              load_fault
);
  localparam int unsigned FW = PW + 1;
  localparam int unsigned CW = NCH * FW;

  // synchronised bits: [0] select, [1] programming clock, [2] mixer clock
  logic [2:0] s_lvl;
  logic [2:0] s_dly;

  cfg_sync #(.N(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({mix_clk, prog_clk, prog_sel_n}),
    .lvl(s_lvl), .dly(s_dly)
  );

  logic din_m, din_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_m <= 1'b0;
      din_s <= 1'b0;
    end else begin
      din_m <= prog_din;
      din_s <= din_m;
    end
  end

  // named internal events
  logic sel_active, pclk_rise, pclk_fall, shift_en, load_ev, mix_edge;
  assign sel_active = ~s_lvl[0];
  assign load_ev    = s_lvl[0] & ~s_dly[0];
  assign pclk_rise  = s_lvl[1] & ~s_dly[1];
  assign pclk_fall  = ~s_lvl[1] & s_dly[1];
  assign shift_en   = pclk_rise & sel_active;
  assign mix_edge   = s_lvl[2] ^ s_dly[2];

  logic [CW-1:0] chain;

  cfg_shift_chain #(.NCH(NCH), .FW(FW)) u_chain (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_en), .out_en(pclk_fall), .din(din_s),
    .chain(chain), .dout(prog_dout)
  );

  cfg_preset_bank #(.NCH(NCH), .PW(PW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_ev), .chain(chain),
    .ch_phase(ch_phase), .ch_enable(ch_enable), .load_pulse(load_pulse)
  );

  cfg_load_guard #(.WIN(WIN)) u_guard (
    .clk(clk), .rst_n(rst_n),
    .load_ev(load_ev), .mix_edge(mix_edge), .load_fault(load_fault)
  );

  assert_load_pulse_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> load_pulse);
endmodule

// File: tb/tb_cwd_cfg_port.sv
module tb_cwd_cfg_port;
  localparam int NB = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_clk = 1'b0, prog_sel_n = 1'b1, prog_din = 1'b0, mix_clk = 1'b0;
  logic prog_dout, load_pulse, load_fault;
  logic [31:0] ch_phase;
  logic [7:0]  ch_enable;

  always #4 clk = ~clk;

  cwd_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .prog_clk(prog_clk), .prog_sel_n(prog_sel_n),
    .prog_din(prog_din), .prog_dout(prog_dout), .mix_clk(mix_clk),
    .ch_phase(ch_phase), .ch_enable(ch_enable),
    .load_pulse(load_pulse), .load_fault(load_fault)
  );

  int checks = 0, fails = 0, loads_seen = 0;
  bit done = 0, dout_chk = 0, mix_run = 0;
  logic [NB-1:0] model = '0;
  logic [NB-1:0] exp_q[$];
  string         tag_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: one serial bit; the model restates the chain as a reference vector
  task automatic send_bit(input logic b);
    prog_din = b;
    wait_clk(6);
    if (dout_chk) check(prog_dout == model[0], "R5", "dout before rise", 64'(prog_dout), 64'(model[0]));
    prog_clk = 1'b1;
    model = {b, model[NB-1:1]};
    wait_clk(6);
    prog_clk = 1'b0;
    wait_clk(6);
  endtask

  task automatic do_load(input string tag);
    exp_q.push_back(model);
    tag_q.push_back(tag);
    prog_sel_n = 1'b1;
    wait_clk(30);
  endtask

  // monitor: pop an expected preset image at each load strobe
  logic prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (load_pulse && prev_pulse) check(1'b0, "R8", "pulse longer than one cycle", 64'd1, 64'd0);
      if (load_pulse) begin
        logic [NB-1:0] got;
        for (int c = 0; c < 8; c++) begin
          got[c*5 +: 4] = ch_phase[c*4 +: 4];
          got[c*5 + 4]  = ch_enable[c];
        end
        loads_seen++;
        if (exp_q.size() == 0) check(1'b0, "R8", "unexpected load", 64'(got), 64'd0);
        else begin
          logic [NB-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, "preset image", 64'(got), 64'(e));
        end
      end
      prev_pulse <= load_pulse;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (mix_run) begin
        repeat (2) @(posedge clk);
        mix_clk = ~mix_clk;
      end
    end
  end

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [NB-1:0] word;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    check(ch_phase == '0, "R1", "phase after reset", 64'(ch_phase), 64'd0);
    check(ch_enable == '0, "R1", "enable after reset", 64'(ch_enable), 64'd0);
    check(prog_dout == 1'b0, "R1", "dout after reset", 64'(prog_dout), 64'd0);
    check(load_fault == 1'b0, "R1", "fault after reset", 64'(load_fault), 64'd0);
    check(load_pulse == 1'b0, "R1", "pulse after reset", 64'(load_pulse), 64'd0);

    // R3/R4: channel c gets enable=c[0], phase=c+3, fields sent LSB first, channel 0 first
    prog_sel_n = 1'b0; wait_clk(4);
    for (int c = 0; c < 8; c++) begin
      logic [4:0] f;
      f = {1'(c & 1), 4'((c + 3) & 15)};
      for (int b = 0; b < 5; b++) send_bit(f[b]);
    end
    do_load("R3");
    for (int c = 0; c < 8; c++) begin
      check(ch_phase[c*4 +: 4] == 4'((c + 3) & 15), "R4", "phase field", 64'(ch_phase[c*4 +: 4]), 64'((c + 3) & 15));
      check(ch_enable[c] == 1'(c & 1), "R4", "enable field", 64'(ch_enable[c]), 64'(c & 1));
    end

    // R5: second word; the previous word must appear on dout bit by bit
    word = 40'hA5_3C_96_E1_0F;
    dout_chk = 1;
    prog_sel_n = 1'b0; wait_clk(4);
    for (int i = 0; i < NB; i++) send_bit(word[i]);
    dout_chk = 0;
    do_load("R8");

    // R2: clocks and data with select high must not move the chain
    for (int i = 0; i < 10; i++) begin
      prog_din = i[0];
      wait_clk(4); prog_clk = 1'b1; wait_clk(6); prog_clk = 1'b0; wait_clk(4);
    end
    check(prog_dout == model[0], "R2", "dout after ignored clocks", 64'(prog_dout), 64'(model[0]));
    prog_sel_n = 1'b0; wait_clk(8);
    do_load("R2");

    // R6: 47 bits, only the last 40 kept
    prog_sel_n = 1'b0; wait_clk(4);
    for (int i = 0; i < 47; i++) send_bit(1'((i * 7 + 3) % 5 == 0));
    do_load("R6");

    // R7: 13 bits only
    prog_sel_n = 1'b0; wait_clk(4);
    for (int i = 0; i < 13; i++) send_bit(1'(i % 3 == 1));
    do_load("R7");

    // R9: free-running mixer clock across the load
    mix_run = 1;
    prog_sel_n = 1'b0; wait_clk(20);
    do_load("R9");
    mix_run = 0;
    wait_clk(6);
    check(load_fault == 1'b1, "R9", "fault with running mixer", 64'(load_fault), 64'd1);

    // R10: single pulse 60 cycles before the load is outside the window
    prog_sel_n = 1'b0; wait_clk(4);
    mix_clk = ~mix_clk; wait_clk(2); mix_clk = ~mix_clk;
    wait_clk(60);
    do_load("R10");
    check(load_fault == 1'b0, "R10", "fault cleared by clean load", 64'(load_fault), 64'd0);

    // R9: single pulse two cycles before the load edge
    prog_sel_n = 1'b0; wait_clk(20);
    mix_clk = ~mix_clk; wait_clk(2); mix_clk = ~mix_clk; wait_clk(2);
    do_load("R9");
    check(load_fault == 1'b1, "R9", "fault with pulse near load", 64'(load_fault), 64'd1);

    // R10: quiet load clears it again
    prog_sel_n = 1'b0; wait_clk(20);
    do_load("R10");
    check(load_fault == 1'b0, "R10", "fault cleared again", 64'(load_fault), 64'd0);

    wait_clk(10);
    check(exp_q.size() == 0, "R8", "pending loads", 64'(exp_q.size()), 64'd0);
    check(loads_seen == 9, "R8", "load count", 64'(loads_seen), 64'd9);
    summary();
  end
endmodule